// File: doc/BRIEF.md
# Arithmetic Decoder with Error Localisation

This block is an integer arithmetic decoder for a fixed symbol model whose top slice of the frequency table is reserved and never encoded. Code bits arrive one at a time through a valid/ready handshake. Decoded symbol indices leave as single-cycle pulses. The decoder keeps a low/high interval and a code-value register, both `PR` bits wide. It narrows the interval for each decoded symbol. It then renormalises by doubling the interval, using three cases: lower half, upper half and middle straddle. The middle-straddle doublings are counted as pending.

If the code value ever selects the reserved slice, the data are corrupt. The decoder stops and reports the symbol position where this happened and the last input bit it had consumed. Bits after that position carry no information.

Decoding is grouped into extended steps. An extended step closes at a concluded point, meaning the interval needs no more doubling, once it has decoded at least one symbol, consumed at least one renormalisation bit, and has no pending middle doublings. Each closed step is pushed onto a small stack as four fields: first bit, last bit, first symbol and last symbol. A later stage can walk this stack to map symbol positions back to bit positions.

Top module: `arith_dec_loc`

## Requirements
- R1: After reset, `done_o`, `err_o`, `ovf_o`, `sym_valid_o` and `bit_ready_o` are low and `count_o` is zero.
- R2: After `start_i`, the decoder first loads `PR` bits into its code value before any symbol is produced. The interval starts as [0, 2^PR - 1].
- R3: With the default model, symbol index 0 has frequency 20, index 1 has 10 and index 2 has 20, in that cumulative order, and the reserved slice of 10 sits above them, for a total of 60. A correctly encoded stream decodes to the encoded symbol indices, in order, whatever pattern of stalls appears on `bit_valid_i`.
- R4: The stream length `nbits_i` is captured at start. Input positions at or beyond it are read as zeros, and `bit_ready_o` stays low for them.
- R5: After exactly `nsym_i` symbols with no reserved-slice hit, `done_o` rises and holds until the next start. No further symbols are emitted.
- R6: Hitting the reserved slice raises `err_o`. `err_sym_o` equals the number of symbols already emitted, which is the 0-based position of the failing symbol. No symbol pulse accompanies or follows the error.
- R7: `err_bit_o` is the 0-based index of the last input bit consumed when the error is detected. Priming bits are counted from index 0.
- R8: Stack entries tile the stream. Entry 0 starts at bit 0 and symbol 0. Each later entry starts one past the previous entry's last bit and last symbol. Every entry holds at least one symbol.
- R9: On completion, any open step is pushed, so the last entry ends at symbol `nsym_i - 1` unless the stack overflowed.
- R10: The stack holds `DEPTH` entries. A push into a full stack sets `ovf_o`, which stays set, and `count_o` stays at `DEPTH`. Decoding continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block; accepted when idle, done or errored |
| nsym_i | input | POS_W | Symbols expected in the block |
| nbits_i | input | POS_W | Bits available in the stream |
| bit_i | input | 1 | Code bit |
| bit_valid_i | input | 1 | Code bit valid |
| bit_ready_o | output | 1 | Decoder takes a bit this cycle if valid |
| sym_valid_o | output | 1 | Decoded symbol pulse |
| sym_o | output | SW | Decoded symbol index |
| done_o | output | 1 | Block decoded without error |
| err_o | output | 1 | Reserved slice hit, decoding halted |
| err_sym_o | output | POS_W | Symbol position of the error |
| err_bit_o | output | POS_W | Estimated last bit position of the error |
| ovf_o | output | 1 | Stack overflowed |
| count_o | output | CW | Stack entries held |
| rd_idx_i | input | IW | Stack read index |
| rd_bit_first_o | output | POS_W | First bit of the addressed entry |
| rd_bit_last_o | output | POS_W | Last bit of the addressed entry |
| rd_sym_first_o | output | POS_W | First symbol of the addressed entry |
| rd_sym_last_o | output | POS_W | Last symbol of the addressed entry |

## Verification
The bench sweeps every four-symbol message, and each single-symbol message, through a bench-side encoder, with and without input stalls. A decoder that mishandled the middle-straddle doubling, or dropped a stalled bit, would return wrong indices.

Two hand-worked streams hit the reserved slice at symbol 0 and at symbol 1. Off-by-one bit or symbol bookkeeping would show up there as a wrong `err_bit_o` (7 and 9) or a wrong stack entry.

An all-zero stream of length zero must decode without ever raising `bit_ready_o`. A long message must overflow a four-entry stack while still decoding correctly. Corrupted streams check that no symbol leaks out after an error.

// File: rtl/arith_dec_pkg.sv
package arith_dec_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PRIME, ST_RUN, ST_DONE, ST_ERR} dec_state_e;
endpackage

// File: rtl/adc_model.sv
module adc_model #(
  parameter int          PR   = 8,
  parameter int          NSYM = 3,
  parameter int unsigned FREQ [NSYM] = '{20, 10, 20},
  parameter int unsigned FORB = 10,
  parameter int          SW   = $clog2(NSYM + 1)
) (
  input  logic [PR-1:0] low_i,
  input  logic [PR-1:0] high_i,
  input  logic [PR-1:0] val_i,
  output logic [SW-1:0] sym_o,
  output logic          forb_o,
  output logic [PR-1:0] low_o,
  output logic [PR-1:0] high_o
);
  function automatic int unsigned cum_at(input int k);
    int unsigned s;
    s = 0;
    for (int j = 0; j < NSYM; j++) if (j < k) s += FREQ[j];
    if (k > NSYM) s += FORB;
    return s;
  endfunction

  localparam int unsigned TOT = cum_at(NSYM + 1);
  localparam int RW = PR + 1;
  localparam int PW = RW + $clog2(TOT + 1);

  logic [RW-1:0] rng;
  logic [PW-1:0] num, tgt, lo_c, hi_c;

  always_comb begin
    rng  = {1'b0, high_i} - {1'b0, low_i} + RW'(1);
    num  = PW'({1'b0, val_i} - {1'b0, low_i}) + PW'(1);
    num  = num * PW'(TOT) - PW'(1);
    tgt  = num / PW'(rng);
    sym_o = '0;
    lo_c  = '0;
    hi_c  = PW'(cum_at(1));
    for (int k = 0; k <= NSYM; k++) begin
      if (tgt >= PW'(cum_at(k))) begin
        sym_o = SW'(k);
        lo_c  = PW'(cum_at(k));
        hi_c  = PW'(cum_at(k + 1));
      end
    end
    low_o  = PR'(PW'(low_i) + PW'(rng) * lo_c / PW'(TOT));
    high_o = PR'(PW'(low_i) + PW'(rng) * hi_c / PW'(TOT) - PW'(1));
    forb_o = (sym_o == SW'(NSYM));
  end
endmodule

// File: rtl/adc_renorm.sv
module adc_renorm #(
  parameter int PR = 8
) (
  input  logic [PR-1:0] low_i,
  input  logic [PR-1:0] high_i,
  input  logic [PR-1:0] val_i,
  input  logic          bit_i,
  output logic          need_o,
  output logic          e3_o,
  output logic [PR-1:0] low_o,
  output logic [PR-1:0] high_o,
  output logic [PR-1:0] val_o
);
  localparam logic [PR-1:0] HALF = PR'(1) << (PR - 1);
  localparam logic [PR-1:0] QTR  = PR'(1) << (PR - 2);
  localparam logic [PR-1:0] Q3   = HALF + QTR;

  logic [PR-1:0] off;

  always_comb begin
    off    = '0;
    need_o = 1'b1;
    e3_o   = 1'b0;
    if (high_i < HALF)                       off = '0;
    else if (low_i >= HALF)                  off = HALF;
    else if (low_i >= QTR && high_i < Q3) begin
      off  = QTR;
      e3_o = 1'b1;
    end else need_o = 1'b0;
    low_o  = (low_i - off) << 1;
    high_o = ((high_i - off) << 1) | PR'(1);
    val_o  = ((val_i - off) << 1) | PR'(bit_i);
  end
endmodule

// File: rtl/adc_stack.sv
module adc_stack #(
  parameter int DEPTH = 4,
  parameter int POS_W = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [POS_W-1:0] bf_i,
  input  logic [POS_W-1:0] bl_i,
  input  logic [POS_W-1:0] sf_i,
  input  logic [POS_W-1:0] sl_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [CW-1:0]    count_o,
  output logic             ovf_o,
  output logic [POS_W-1:0] rd_bf_o,
  output logic [POS_W-1:0] rd_bl_o,
  output logic [POS_W-1:0] rd_sf_o,
  output logic [POS_W-1:0] rd_sl_o
);
  logic [POS_W-1:0] m_bf [DEPTH];
  logic [POS_W-1:0] m_bl [DEPTH];
  logic [POS_W-1:0] m_sf [DEPTH];
  logic [POS_W-1:0] m_sl [DEPTH];
  logic full;

  assign full = (count_o == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (clr_i) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_o <= 1'b1;
      else      count_o <= count_o + CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i && !full) begin
      m_bf[IW'(count_o)] <= bf_i;
      m_bl[IW'(count_o)] <= bl_i;
      m_sf[IW'(count_o)] <= sf_i;
      m_sl[IW'(count_o)] <= sl_i;
    end
  end

  assign rd_bf_o = m_bf[rd_idx_i];
  assign rd_bl_o = m_bl[rd_idx_i];
  assign rd_sf_o = m_sf[rd_idx_i];
  assign rd_sl_o = m_sl[rd_idx_i];

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  // R10
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o);
  // R8
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clr_i && !full |=> count_o == $past(count_o) + CW'(1));
endmodule

// File: rtl/arith_dec_loc.sv
module arith_dec_loc
  import arith_dec_pkg::*;
#(
  parameter int          PR    = 8,
  parameter int          NSYM  = 3,
  parameter int unsigned FREQ [NSYM] = '{20, 10, 20},
  parameter int unsigned FORB  = 10,
  parameter int          DEPTH = 4,
  parameter int          POS_W = 16,
  parameter int          SW    = $clog2(NSYM + 1),
  parameter int          IW    = $clog2(DEPTH),
  parameter int          CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [POS_W-1:0] nsym_i,
  input  logic [POS_W-1:0] nbits_i,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  output logic             bit_ready_o,
  output logic             sym_valid_o,
  output logic [SW-1:0]    sym_o,
  output logic             done_o,
  output logic             err_o,
  output logic [POS_W-1:0] err_sym_o,
  output logic [POS_W-1:0] err_bit_o,
  output logic             ovf_o,
  output logic [CW-1:0]    count_o,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [POS_W-1:0] rd_bit_first_o,
  output logic [POS_W-1:0] rd_bit_last_o,
  output logic [POS_W-1:0] rd_sym_first_o,
  output logic [POS_W-1:0] rd_sym_last_o
);
  dec_state_e       state_q;
  logic [PR-1:0]    low_q, high_q, val_q;
  logic [POS_W-1:0] sc3_q, cons_q, nsym_q, nbits_q, scnt_q, prime_q;
  logic [POS_W-1:0] stp_bf_q, stp_sf_q;
  logic             stp_sym_q, stp_sh_q;

  logic          have_bit, bit_val, bit_ok, start_ok;
  logic          r_need, r_e3;
  logic [PR-1:0] r_low, r_high, r_val, m_low, m_high;
  logic [SW-1:0] m_sym;
  logic          m_forb, closing, fin, run_idle, push;

  assign have_bit = cons_q < nbits_q;
  assign bit_val  = have_bit & bit_i;
  assign bit_ok   = !have_bit || bit_valid_i;
  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_ERR);

  adc_renorm #(.PR(PR)) u_renorm (
    .low_i(low_q), .high_i(high_q), .val_i(val_q), .bit_i(bit_val),
    .need_o(r_need), .e3_o(r_e3), .low_o(r_low), .high_o(r_high), .val_o(r_val)
  );

  adc_model #(.PR(PR), .NSYM(NSYM), .FREQ(FREQ), .FORB(FORB), .SW(SW)) u_model (
    .low_i(low_q), .high_i(high_q), .val_i(val_q),
    .sym_o(m_sym), .forb_o(m_forb), .low_o(m_low), .high_o(m_high)
  );

  // extended step closes at a concluded point with output, input and no pending E3
  assign closing  = stp_sym_q && stp_sh_q && (sc3_q == '0);
  assign fin      = (scnt_q == nsym_q);
  assign run_idle = (state_q == ST_RUN) && !r_need;
  assign push     = run_idle && (fin ? stp_sym_q : closing);

  assign bit_ready_o = have_bit && (state_q == ST_PRIME || (state_q == ST_RUN && r_need));
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);

  adc_stack #(.DEPTH(DEPTH), .POS_W(POS_W), .IW(IW), .CW(CW)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_ok), .push_i(push),
    .bf_i(stp_bf_q), .bl_i(cons_q - POS_W'(1)),
    .sf_i(stp_sf_q), .sl_i(scnt_q - POS_W'(1)),
    .rd_idx_i(rd_idx_i), .count_o(count_o), .ovf_o(ovf_o),
    .rd_bf_o(rd_bit_first_o), .rd_bl_o(rd_bit_last_o),
    .rd_sf_o(rd_sym_first_o), .rd_sl_o(rd_sym_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      low_q       <= '0;
      high_q      <= '1;
      val_q       <= '0;
      sc3_q       <= '0;
      cons_q      <= '0;
      nsym_q      <= '0;
      nbits_q     <= '0;
      scnt_q      <= '0;
      prime_q     <= '0;
      stp_bf_q    <= '0;
      stp_sf_q    <= '0;
      stp_sym_q   <= 1'b0;
      stp_sh_q    <= 1'b0;
      err_sym_o   <= '0;
      err_bit_o   <= '0;
      sym_valid_o <= 1'b0;
      sym_o       <= '0;
    end else begin
      sym_valid_o <= 1'b0;
      case (state_q)
        ST_PRIME: if (bit_ok) begin
          val_q   <= {val_q[PR-2:0], bit_val};
          cons_q  <= cons_q + POS_W'(1);
          prime_q <= prime_q + POS_W'(1);
          if (prime_q == POS_W'(PR - 1)) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (r_need) begin
            if (bit_ok) begin
              low_q    <= r_low;
              high_q   <= r_high;
              val_q    <= r_val;
              cons_q   <= cons_q + POS_W'(1);
              sc3_q    <= r_e3 ? sc3_q + POS_W'(1) : '0;
              stp_sh_q <= 1'b1;
            end
          end else if (fin) begin
            state_q <= ST_DONE;
          end else begin
            if (closing) begin
              stp_bf_q <= cons_q;
              stp_sf_q <= scnt_q;
              stp_sh_q <= 1'b0;
            end
            if (m_forb) begin
              state_q   <= ST_ERR;
              err_sym_o <= scnt_q;
              err_bit_o <= cons_q - POS_W'(1);
            end else begin
              low_q       <= m_low;
              high_q      <= m_high;
              scnt_q      <= scnt_q + POS_W'(1);
              stp_sym_q   <= 1'b1;
              sym_valid_o <= 1'b1;
              sym_o       <= m_sym;
            end
          end
        end
        default: if (start_i) begin
          nsym_q    <= nsym_i;
          nbits_q   <= nbits_i;
          cons_q    <= '0;
          scnt_q    <= '0;
          prime_q   <= '0;
          low_q     <= '0;
          high_q    <= '1;
          val_q     <= '0;
          sc3_q     <= '0;
          stp_bf_q  <= '0;
          stp_sf_q  <= '0;
          stp_sym_q <= 1'b0;
          stp_sh_q  <= 1'b0;
          err_sym_o <= '0;
          err_bit_o <= '0;
          state_q   <= ST_PRIME;
        end
      endcase
    end
  end

  // R3
  interval_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN |-> (low_q <= high_q && val_q >= low_q && val_q <= high_q));
  // R6
  no_sym_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !sym_valid_o);
  // R4
  bit_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ready_o && bit_valid_i |=> cons_q == $past(cons_q) + POS_W'(1));
  // R5
  done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> scnt_q == nsym_q);
endmodule

// File: tb/sim_arith_dec_loc.sv
`timescale 1ns/1ps
module sim_arith_dec_loc;
  localparam int PR = 8;
  localparam int POS_W = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [POS_W-1:0] nsym_i = '0, nbits_i = '0;
  logic bit_i, bit_valid_i, bit_ready_o, sym_valid_o;
  logic [1:0] sym_o;
  logic done_o, err_o, ovf_o;
  logic [POS_W-1:0] err_sym_o, err_bit_o;
  logic [2:0] count_o;
  logic [1:0] rd_idx_i = '0;
  logic [POS_W-1:0] rd_bf, rd_bl, rd_sf, rd_sl;

  always #2.5 clk = ~clk;

  arith_dec_loc #(.PR(PR), .DEPTH(DEPTH), .POS_W(POS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .nsym_i(nsym_i), .nbits_i(nbits_i),
    .bit_i(bit_i), .bit_valid_i(bit_valid_i), .bit_ready_o(bit_ready_o),
    .sym_valid_o(sym_valid_o), .sym_o(sym_o), .done_o(done_o), .err_o(err_o),
    .err_sym_o(err_sym_o), .err_bit_o(err_bit_o), .ovf_o(ovf_o), .count_o(count_o),
    .rd_idx_i(rd_idx_i), .rd_bit_first_o(rd_bf), .rd_bit_last_o(rd_bl),
    .rd_sym_first_o(rd_sf), .rd_sym_last_o(rd_sl)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  logic ebits [0:511];
  int elen;
  int seq [0:31];
  logic [1:0] got [0:63];
  int ngot, bidx;
  logic tb_clr = 1'b1, use_stall = 1'b0, seen_ready;
  logic [3:0] lf = 4'h9;

  assign bit_i = (bidx < 512) ? ebits[bidx] : 1'b0;
  assign bit_valid_i = !use_stall || lf[0];

  always @(posedge clk) begin
    lf <= {lf[2:0], lf[3] ^ lf[2]};
    if (tb_clr) begin
      ngot <= 0; bidx <= 0; seen_ready <= 1'b0;
    end else begin
      if (bit_ready_o) seen_ready <= 1'b1;
      if (bit_ready_o && bit_valid_i) bidx <= bidx + 1;
      if (sym_valid_o && ngot < 64) begin
        got[ngot] <= sym_o; ngot <= ngot + 1;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        nfail++; $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        summary(); $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++; $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int cumv(input int k);
    case (k) 0: return 0; 1: return 20; 2: return 30; 3: return 50; default: return 60; endcase
  endfunction

  task automatic emit(input bit b);
    ebits[elen] = b; elen++;
  endtask

  // bench-side encoder of the R3 model, with final flush
  task automatic encode(input int n);
    int lo, hi, rng, pend;
    for (int i = 0; i < 512; i++) ebits[i] = 1'b0;
    elen = 0; lo = 0; hi = 255; pend = 0;
    for (int i = 0; i < n; i++) begin
      rng = hi - lo + 1;
      hi = lo + rng * cumv(seq[i] + 1) / 60 - 1;
      lo = lo + rng * cumv(seq[i]) / 60;
      forever begin
        if (hi < 128) begin
          emit(0); for (int j = 0; j < pend; j++) emit(1); pend = 0;
        end else if (lo >= 128) begin
          emit(1); for (int j = 0; j < pend; j++) emit(0); pend = 0;
          lo -= 128; hi -= 128;
        end else if (lo >= 64 && hi < 192) begin
          pend++; lo -= 64; hi -= 64;
        end else break;
        lo = 2 * lo; hi = 2 * hi + 1;
      end
    end
    pend++;
    if (lo < 64) begin emit(0); for (int j = 0; j < pend; j++) emit(1); end
    else begin emit(1); for (int j = 0; j < pend; j++) emit(0); end
  endtask

  task automatic run(input int ns, input int nb, input bit st);
    int t;
    @(negedge clk);
    tb_clr = 1'b1; nsym_i = POS_W'(ns); nbits_i = POS_W'(nb); use_stall = st; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; tb_clr = 1'b0;
    t = 0;
    while (!(done_o || err_o) && t < 4000) begin @(negedge clk); t++; end
    chk(t < 4000, "R5 finish", t, 4000);
  endtask

  task automatic check_clean(input int n);
    int mis, pbl, psl;
    bit tile;
    chk(done_o && !err_o, "R5 done", int'(done_o), 1);
    mis = 0;
    for (int i = 0; i < n && i < ngot; i++) if (int'(got[i]) != seq[i]) mis++;
    chk(mis == 0 && ngot == n, "R3 symbols", ngot, n);
    tile = 1'b1; pbl = -1; psl = -1;
    for (int i = 0; i < int'(count_o); i++) begin
      rd_idx_i = 2'(i); #1;
      if (int'(rd_bf) != pbl + 1 || int'(rd_sf) != psl + 1 || rd_sl < rd_sf) tile = 1'b0;
      pbl = int'(rd_bl); psl = int'(rd_sl);
    end
    chk(tile && count_o > 0, "R8 tiling", int'(count_o), 1);
    if (!ovf_o) chk(psl == n - 1, "R9 last entry", psl, n - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(!done_o && !err_o && !ovf_o && !sym_valid_o && !bit_ready_o && count_o == 0,
        "R1 reset", int'(count_o), 0);

    // R3 single symbols, R2 priming implied
    for (int s = 0; s < 3; s++) begin
      seq[0] = s; encode(1); run(1, elen, 1'b0); check_clean(1);
    end
    // R3 exhaustive length four, stalls on odd patterns
    for (int v = 0; v < 81; v++) begin
      seq[0] = v % 3; seq[1] = (v / 3) % 3; seq[2] = (v / 9) % 3; seq[3] = v / 27;
      encode(4); run(4, elen, v[0]); check_clean(4);
    end
    // R10 long message overflows stack
    for (int i = 0; i < 16; i++) seq[i] = (i * 7 + i / 3) % 3;
    encode(16); run(16, elen, 1'b1); check_clean(16);
    chk(ovf_o && count_o == 3'(DEPTH), "R10 overflow", int'(count_o), DEPTH);

    // R4 empty stream reads zeros: all index 0, no handshake
    for (int i = 0; i < 5; i++) seq[i] = 0;
    for (int i = 0; i < 512; i++) ebits[i] = 1'b1;
    run(5, 0, 1'b0);
    check_clean(5);
    chk(!seen_ready, "R4 no ready past end", int'(seen_ready), 0);

    // R6 R7 all ones: reserved slice on symbol 0 after priming
    run(4, 8, 1'b0);
    chk(err_o && !done_o, "R6 error flag", int'(err_o), 1);
    chk(err_sym_o == 0 && ngot == 0, "R6 error symbol", int'(err_sym_o), 0);
    chk(err_bit_o == 7, "R7 error bit", int'(err_bit_o), 7);
    chk(count_o == 0, "R8 no entry", int'(count_o), 0);

    // R7 R8 stream 0111_1111: index 1 decoded, error at symbol 1, bit 9
    for (int i = 0; i < 512; i++) ebits[i] = 1'b0;
    for (int i = 1; i < 8; i++) ebits[i] = 1'b1;
    run(4, 8, 1'b1);
    chk(err_o && err_sym_o == 1 && ngot == 1 && got[0] == 2'd1, "R6 second", int'(err_sym_o), 1);
    chk(err_bit_o == 9, "R7 second", int'(err_bit_o), 9);
    rd_idx_i = 2'd0; #1;
    chk(count_o == 1 && rd_bf == 0 && rd_bl == 9 && rd_sf == 0 && rd_sl == 0,
        "R8 entry", int'(rd_bl), 9);

    // R6 R7 corrupted streams
    for (int v = 0; v < 81; v += 7) begin
      seq[0] = v % 3; seq[1] = (v / 3) % 3; seq[2] = (v / 9) % 3; seq[3] = v / 27;
      encode(4);
      ebits[v % elen] = !ebits[v % elen];
      run(4, elen, 1'b0);
      if (err_o) begin
        chk(ngot == int'(err_sym_o), "R6 no later symbol", ngot, int'(err_sym_o));
        chk(err_bit_o >= POS_W'(PR - 1), "R7 bit bound", int'(err_bit_o), PR - 1);
      end else chk(done_o && ngot == 4, "R5 corrupt done", ngot, 4);
    end

    summary();
    $finish;
  end
endmodule